// File: doc/BRIEF.md
# Parallel Flash Sector-Erase Sequencer

This block erases a contiguous range of sectors on a 16-bit parallel NOR-style flash that sits on an asynchronous memory bus. The host gives a first and last sector index and a per-sector protect mask, then pulses start. The block first checks the whole range against the protect mask. If the range is clear, it erases the sectors one at a time. For each sector it drives the six-cycle unlock and erase command sequence, then polls the status word at the sector base. After each sector it returns the device to read-array mode.

Sector placement comes from a parameter table of word offsets, so sectors of unequal size are supported. Bus timing is set by parameters: address and data setup before the write strobe, the strobe width, hold after the strobe, and read access time. The block stops at the first sector that fails or times out and reports that sector's index. A successful run ends with a configurable settle delay before done is raised.

Top module: `flash_erase_seq`

## Requirements
- R1: If any sector between first and last (inclusive) has its protect bit set, the run ends with result 2 (protected) and a done pulse, and chip enable never goes low during that run.
- R2: Each sector erase issues six write cycles in this order: 0xAA to word 0x555, 0x55 to word 0x2AA, 0x80 to word 0x555, 0xAA to word 0x555, 0x55 to word 0x2AA, then 0x30 to the sector base word.
- R3: A word address W appears on the bus as byte address FLASH_BASE + 2*W. Sector s has base word SECT_WOFS[s], so word 0x555 appears at FLASH_BASE + 0xAAA.
- R4: After the confirm write, the block reads the sector base address repeatedly. A read with bit 7 set completes the sector. A read with bit 7 clear and bit 5 set fails it, and the run then ends with result 1.
- R5: If polling of a sector lasts TMO_CYC cycles without completion or failure, the block writes 0xF0 to word 0x555 and ends with result 3 (timeout).
- R6: Every sector ends with a write of 0xF0 to word 0x555 before any cycle for the next sector, whether it completed, failed or timed out.
- R7: Write enable goes low only while chip enable is low, the data bus is driven and output enable is high. Address and data stay unchanged from before write enable falls until after it rises. Output enable is never low while the data bus is driven.
- R8: The run stops at the first failing or timed-out sector. fail_sect_o reports that sector's index, and no later sector receives any write.
- R9: After reset, busy and done are low and the bus is idle. Busy rises after an accepted start and falls in the cycle that done pulses for one cycle with the result valid. A start pulse while busy is ignored.
- R10: After the last sector of a successful run, done is delayed by at least SETTLE_CYC cycles after the final write strobe rises. The result is 0 (ok).
- R11: A range with first greater than last issues no bus cycles and ends with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a new range |
| first_i | input | SW | First sector index |
| last_i | input | SW | Last sector index |
| protect_i | input | SECT_CNT | Per-sector protect mask |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 2 | 0 ok, 1 erase failed, 2 protected, 3 timeout |
| fail_sect_o | output | SW | Index of the sector that failed or timed out |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_dq_o | output | DATA_W | Write data |
| fl_dq_oe_o | output | 1 | Write data drive enable |
| fl_dq_i | input | DATA_W | Read data from flash |
| fl_ce_n_o | output | 1 | Chip enable, active low |
| fl_we_n_o | output | 1 | Write enable, active low |
| fl_oe_n_o | output | 1 | Output enable, active low |

## Verification
The bench builds the block with setup 2, strobe 2, hold 1 and access 2 cycles, a 60-cycle poll timeout and a 20-cycle settle delay. The short timeout lets a never-finishing sector reach result 3 within a few hundred cycles. The sector table is irregular and the flash base is set to 0x200000, so both the table lookup and the doubled word-to-byte mapping are exercised at a non-zero offset. A bench flash model can finish, fail or hang on a chosen sector after a chosen number of busy polls. This reaches a first-sector failure, a mid-range failure, instant completion and protection bits both inside and outside the range.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_FAIL = 2'd1,
    RES_PROT = 2'd2,
    RES_TMO  = 2'd3
  } fe_res_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_CHECK,
    CS_CMD,
    CS_POLL,
    CS_RST,
    CS_SETTLE
  } fe_cstate_e;

  typedef enum logic [2:0] {
    BP_IDLE,
    BP_SETUP,
    BP_PULSE,
    BP_HOLD,
    BP_READ
  } fe_bphase_e;

  localparam logic [7:0]  CMD_KEY_A     = 8'hAA;
  localparam logic [7:0]  CMD_KEY_B     = 8'h55;
  localparam logic [7:0]  CMD_ERASE_ARM = 8'h80;
  localparam logic [7:0]  CMD_SECT_GO   = 8'h30;
  localparam logic [7:0]  CMD_READ_MODE = 8'hF0;
  localparam logic [11:0] WA_KEY_A      = 12'h555;
  localparam logic [11:0] WA_KEY_B      = 12'h2AA;
  localparam int unsigned ST_DONE_BIT   = 7;
  localparam int unsigned ST_FAIL_BIT   = 5;
  localparam int unsigned CMD_STEPS     = 6;

endpackage

// File: rtl/fe_wait_cnt.sv
module fe_wait_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign hit_o  = (cnt_q >= CW'(LIMIT));
  assign cnt_en = !run_i || !hit_o;

  always_comb begin
    if (!run_i) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fe_prot_chk.sv
module fe_prot_chk #(
  parameter int unsigned SECT_CNT = 8,
  parameter int unsigned SW       = 3
) (
  input  logic [SW-1:0]       first_i,
  input  logic [SW-1:0]       last_i,
  input  logic [SECT_CNT-1:0] mask_i,
  output logic                hit_o
);
  logic [SECT_CNT-1:0] in_rng;

  for (genvar i = 0; i < SECT_CNT; i++) begin : g_sect
    assign in_rng[i] = mask_i[i] && (SW'(i) >= first_i) && (SW'(i) <= last_i);
  end

  assign hit_o = |in_rng;
endmodule

// File: rtl/fe_bus_eng.sv
module fe_bus_eng
  import fe_pkg::*;
#(
  parameter int unsigned     ADDR_W     = 24,
  parameter int unsigned     DATA_W     = 16,
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter int unsigned     T_SU       = 2,
  parameter int unsigned     T_WP       = 2,
  parameter int unsigned     T_HD       = 1,
  parameter int unsigned     T_ACC      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-2:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_dq_o,
  output logic              fl_dq_oe_o,
  input  logic [DATA_W-1:0] fl_dq_i,
  output logic              fl_ce_n_o,
  output logic              fl_we_n_o,
  output logic              fl_oe_n_o
);
  localparam int unsigned TM1  = (T_SU > T_WP) ? T_SU : T_WP;
  localparam int unsigned TM2  = (T_HD > T_ACC) ? T_HD : T_ACC;
  localparam int unsigned TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int unsigned CW   = $clog2(TMAX + 1);

  fe_bphase_e        ph_q, ph_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              ack_q, ack_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q + 1'b1;
    addr_d = addr_q;
    data_d = data_q;
    rd_d   = rd_q;
    ack_d  = 1'b0;
    unique case (ph_q)
      BP_IDLE: begin
        cnt_d = '0;
        if (req_i) begin
          addr_d = FLASH_BASE + {req_addr_i, 1'b0};
          data_d = req_data_i;
          ph_d   = req_wr_i ? BP_SETUP : BP_READ;
        end
      end
      BP_SETUP: if (cnt_q == CW'(T_SU - 1)) begin
        ph_d  = BP_PULSE;
        cnt_d = '0;
      end
      BP_PULSE: if (cnt_q == CW'(T_WP - 1)) begin
        ph_d  = BP_HOLD;
        cnt_d = '0;
      end
      BP_HOLD: if (cnt_q == CW'(T_HD - 1)) begin
        ph_d  = BP_IDLE;
        cnt_d = '0;
        ack_d = 1'b1;
      end
      BP_READ: if (cnt_q == CW'(T_ACC - 1)) begin
        ph_d  = BP_IDLE;
        cnt_d = '0;
        rd_d  = fl_dq_i;
        ack_d = 1'b1;
      end
      default: ph_d = BP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= BP_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
      rd_q   <= rd_d;
      ack_q  <= ack_d;
    end
  end

  assign ack_o      = ack_q;
  assign rd_data_o  = rd_q;
  assign fl_addr_o  = addr_q;
  assign fl_dq_o    = data_q;
  assign fl_dq_oe_o = (ph_q == BP_SETUP) || (ph_q == BP_PULSE) || (ph_q == BP_HOLD);
  assign fl_ce_n_o  = (ph_q == BP_IDLE);
  assign fl_we_n_o  = (ph_q != BP_PULSE);
  assign fl_oe_n_o  = (ph_q != BP_READ);
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
#(
  parameter int unsigned SECT_CNT = 8,
  parameter int unsigned SW       = 3,
  parameter int unsigned WAW      = 23,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SW-1:0]       first_i,
  input  logic [SW-1:0]       last_i,
  input  logic [SECT_CNT-1:0] protect_i,
  input  logic                prot_hit_i,
  input  logic                tmo_hit_i,
  input  logic                settle_hit_i,
  input  logic                ack_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  input  logic [WAW-1:0]      sect_wofs_i,
  output logic [SW-1:0]       first_q_o,
  output logic [SW-1:0]       last_q_o,
  output logic [SECT_CNT-1:0] mask_q_o,
  output logic [SW-1:0]       cur_o,
  output logic                req_o,
  output logic                req_wr_o,
  output logic [WAW-1:0]      req_addr_o,
  output logic [DATA_W-1:0]   req_data_o,
  output logic                tmo_run_o,
  output logic                settle_run_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          result_o,
  output logic [SW-1:0]       fail_sect_o
);
  fe_cstate_e          st_q, st_d;
  logic [2:0]          step_q, step_d;
  logic [SW-1:0]       cur_q, cur_d;
  logic [SW-1:0]       first_q, first_d, last_q, last_d;
  logic [SECT_CNT-1:0] mask_q, mask_d;
  fe_res_e             out_q, out_d;
  fe_res_e             res_q, res_d;
  logic [SW-1:0]       fsect_q, fsect_d;
  logic                infl_q, infl_d;
  logic                done_q, done_d;
  logic                issue;

  assign issue = ((st_q == CS_CMD) || (st_q == CS_POLL) || (st_q == CS_RST)) && !infl_q;

  always_comb begin
    req_wr_o   = 1'b1;
    req_addr_o = WAW'(WA_KEY_A);
    req_data_o = '0;
    unique case (st_q)
      CS_CMD: begin
        unique case (step_q)
          3'd0:    req_data_o = DATA_W'(CMD_KEY_A);
          3'd1: begin
            req_addr_o = WAW'(WA_KEY_B);
            req_data_o = DATA_W'(CMD_KEY_B);
          end
          3'd2:    req_data_o = DATA_W'(CMD_ERASE_ARM);
          3'd3:    req_data_o = DATA_W'(CMD_KEY_A);
          3'd4: begin
            req_addr_o = WAW'(WA_KEY_B);
            req_data_o = DATA_W'(CMD_KEY_B);
          end
          default: begin
            req_addr_o = sect_wofs_i;
            req_data_o = DATA_W'(CMD_SECT_GO);
          end
        endcase
      end
      CS_POLL: begin
        req_wr_o   = 1'b0;
        req_addr_o = sect_wofs_i;
      end
      CS_RST:  req_data_o = DATA_W'(CMD_READ_MODE);
      default: req_data_o = '0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    cur_d   = cur_q;
    first_d = first_q;
    last_d  = last_q;
    mask_d  = mask_q;
    out_d   = out_q;
    res_d   = res_q;
    fsect_d = fsect_q;
    done_d  = 1'b0;
    infl_d  = issue ? 1'b1 : (ack_i ? 1'b0 : infl_q);
    unique case (st_q)
      CS_IDLE: if (start_i) begin
        first_d = first_i;
        last_d  = last_i;
        mask_d  = protect_i;
        st_d    = CS_CHECK;
      end
      CS_CHECK: begin
        out_d = RES_OK;
        if (prot_hit_i) begin
          st_d   = CS_IDLE;
          res_d  = RES_PROT;
          done_d = 1'b1;
        end else if (first_q > last_q) begin
          st_d = CS_SETTLE;
        end else begin
          cur_d  = first_q;
          step_d = '0;
          st_d   = CS_CMD;
        end
      end
      CS_CMD: if (ack_i) begin
        if (step_q == 3'(CMD_STEPS - 1)) st_d = CS_POLL;
        else                             step_d = step_q + 1'b1;
      end
      CS_POLL: if (ack_i) begin
        if (rd_data_i[ST_DONE_BIT]) begin
          out_d = RES_OK;
          st_d  = CS_RST;
        end else if (rd_data_i[ST_FAIL_BIT]) begin
          out_d = RES_FAIL;
          st_d  = CS_RST;
        end else if (tmo_hit_i) begin
          out_d = RES_TMO;
          st_d  = CS_RST;
        end
      end
      CS_RST: if (ack_i) begin
        if (out_q != RES_OK) begin
          st_d    = CS_IDLE;
          res_d   = out_q;
          fsect_d = cur_q;
          done_d  = 1'b1;
        end else if (cur_q == last_q) begin
          st_d = CS_SETTLE;
        end else begin
          cur_d  = cur_q + 1'b1;
          step_d = '0;
          st_d   = CS_CMD;
        end
      end
      CS_SETTLE: if (settle_hit_i) begin
        st_d   = CS_IDLE;
        res_d  = RES_OK;
        done_d = 1'b1;
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CS_IDLE;
      step_q  <= '0;
      cur_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      mask_q  <= '0;
      out_q   <= RES_OK;
      res_q   <= RES_OK;
      fsect_q <= '0;
      infl_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      cur_q   <= cur_d;
      first_q <= first_d;
      last_q  <= last_d;
      mask_q  <= mask_d;
      out_q   <= out_d;
      res_q   <= res_d;
      fsect_q <= fsect_d;
      infl_q  <= infl_d;
      done_q  <= done_d;
    end
  end

  assign first_q_o    = first_q;
  assign last_q_o     = last_q;
  assign mask_q_o     = mask_q;
  assign cur_o        = cur_q;
  assign req_o        = issue;
  assign tmo_run_o    = (st_q == CS_POLL);
  assign settle_run_o = (st_q == CS_SETTLE);
  assign busy_o       = (st_q != CS_IDLE);
  assign done_o       = done_q;
  assign result_o     = res_q;
  assign fail_sect_o  = fsect_q;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SECT_CNT   = 8,
  parameter logic [SECT_CNT*(ADDR_W-1)-1:0] SECT_WOFS = {
    23'h20000, 23'h18000, 23'h10000, 23'h08000,
    23'h04000, 23'h03000, 23'h02000, 23'h00000},
  parameter logic [ADDR_W-1:0] FLASH_BASE = '0,
  parameter int unsigned T_SU       = 2,
  parameter int unsigned T_WP       = 2,
  parameter int unsigned T_HD       = 1,
  parameter int unsigned T_ACC      = 2,
  parameter int unsigned TMO_CYC    = 4000,
  parameter int unsigned SETTLE_CYC = 500,
  localparam int unsigned SW        = (SECT_CNT > 1) ? $clog2(SECT_CNT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SW-1:0]       first_i,
  input  logic [SW-1:0]       last_i,
  input  logic [SECT_CNT-1:0] protect_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [1:0]          result_o,
  output logic [SW-1:0]       fail_sect_o,
  output logic [ADDR_W-1:0]   fl_addr_o,
  output logic [DATA_W-1:0]   fl_dq_o,
  output logic                fl_dq_oe_o,
  input  logic [DATA_W-1:0]   fl_dq_i,
  output logic                fl_ce_n_o,
  output logic                fl_we_n_o,
  output logic                fl_oe_n_o
);
  localparam int unsigned WAW = ADDR_W - 1;

  logic                rst_s1, rst_sn;
  logic [SW-1:0]       first_q, last_q, cur;
  logic [SECT_CNT-1:0] mask_q;
  logic                prot_hit, tmo_hit, settle_hit, tmo_run, settle_run;
  logic                req, req_wr, ack;
  logic [WAW-1:0]      req_addr, sect_wofs;
  logic [DATA_W-1:0]   req_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  assign sect_wofs = SECT_WOFS[int'(cur)*WAW +: WAW];

  fe_prot_chk #(.SECT_CNT(SECT_CNT), .SW(SW)) u_prot (
    .first_i (first_q),
    .last_i  (last_q),
    .mask_i  (mask_q),
    .hit_o   (prot_hit)
  );

  fe_wait_cnt #(.LIMIT(TMO_CYC)) u_tmo (
    .clk   (clk),
    .rst_n (rst_sn),
    .run_i (tmo_run),
    .hit_o (tmo_hit)
  );

  fe_wait_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_sn),
    .run_i (settle_run),
    .hit_o (settle_hit)
  );

  fe_ctrl #(.SECT_CNT(SECT_CNT), .SW(SW), .WAW(WAW), .DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sn),
    .start_i      (start_i),
    .first_i      (first_i),
    .last_i       (last_i),
    .protect_i    (protect_i),
    .prot_hit_i   (prot_hit),
    .tmo_hit_i    (tmo_hit),
    .settle_hit_i (settle_hit),
    .ack_i        (ack),
    .rd_data_i    (rd_data),
    .sect_wofs_i  (sect_wofs),
    .first_q_o    (first_q),
    .last_q_o     (last_q),
    .mask_q_o     (mask_q),
    .cur_o        (cur),
    .req_o        (req),
    .req_wr_o     (req_wr),
    .req_addr_o   (req_addr),
    .req_data_o   (req_data),
    .tmo_run_o    (tmo_run),
    .settle_run_o (settle_run),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .fail_sect_o  (fail_sect_o)
  );

  fe_bus_eng #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLASH_BASE(FLASH_BASE),
    .T_SU(T_SU), .T_WP(T_WP), .T_HD(T_HD), .T_ACC(T_ACC)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_sn),
    .req_i      (req),
    .req_wr_i   (req_wr),
    .req_addr_i (req_addr),
    .req_data_i (req_data),
    .ack_o      (ack),
    .rd_data_o  (rd_data),
    .fl_addr_o  (fl_addr_o),
    .fl_dq_o    (fl_dq_o),
    .fl_dq_oe_o (fl_dq_oe_o),
    .fl_dq_i    (fl_dq_i),
    .fl_ce_n_o  (fl_ce_n_o),
    .fl_we_n_o  (fl_we_n_o),
    .fl_oe_n_o  (fl_oe_n_o)
  );
endmodule

// File: rtl/fe_seq_chk.sv
module fe_seq_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        result_o,
  input logic [ADDR_W-1:0] fl_addr_o,
  input logic [DATA_W-1:0] fl_dq_o,
  input logic              fl_dq_oe_o,
  input logic              fl_ce_n_o,
  input logic              fl_we_n_o,
  input logic              fl_oe_n_o
);
  logic ce_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ce_seen_q <= 1'b0;
    else if (start_i && !busy_o) ce_seen_q <= 1'b0;
    else if (!fl_ce_n_o)         ce_seen_q <= 1'b1;
  end

  AST_PROT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == 2'd2) |-> !ce_seen_q); // R1
  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n_o |-> (!fl_ce_n_o && fl_dq_oe_o && fl_oe_n_o)); // R7
  AST_WE_SETUP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n_o) |-> ($stable(fl_addr_o) && $stable(fl_dq_o))); // R7
  AST_WE_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n_o |=> ($stable(fl_addr_o) && $stable(fl_dq_o))); // R7
  AST_OE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n_o |-> !fl_dq_oe_o); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R9
endmodule

bind flash_erase_seq fe_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o),
  .fl_addr_o  (fl_addr_o),
  .fl_dq_o    (fl_dq_o),
  .fl_dq_oe_o (fl_dq_oe_o),
  .fl_ce_n_o  (fl_ce_n_o),
  .fl_we_n_o  (fl_we_n_o),
  .fl_oe_n_o  (fl_oe_n_o)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int unsigned AW   = 24;
  localparam int unsigned DW   = 16;
  localparam int unsigned NS   = 8;
  localparam int unsigned SWB  = 3;
  localparam int unsigned WAW  = AW - 1;
  localparam logic [NS*WAW-1:0] TBL = {
    23'h20000, 23'h18000, 23'h10000, 23'h08000,
    23'h04000, 23'h03000, 23'h02000, 23'h00000};
  localparam logic [AW-1:0] BASE = 24'h200000;
  localparam int unsigned SETTLE = 20;
  localparam int unsigned TMO    = 60;

  typedef struct packed {
    logic [2:0] first;
    logic [2:0] last;
    logic [7:0] mask;
    logic [1:0] mode;
    logic [2:0] bad;
    logic [3:0] polls;
    logic [1:0] res;
    logic [2:0] fsect;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 8'h00, 2'd0, 3'd0, 4'd3, 2'd0, 3'd0},
    '{3'd2, 3'd4, 8'h00, 2'd0, 3'd0, 4'd1, 2'd0, 3'd0},
    '{3'd1, 3'd3, 8'h04, 2'd0, 3'd0, 4'd1, 2'd2, 3'd0},
    '{3'd5, 3'd7, 8'h01, 2'd0, 3'd0, 4'd2, 2'd0, 3'd0},
    '{3'd3, 3'd6, 8'h00, 2'd1, 3'd4, 4'd2, 2'd1, 3'd4},
    '{3'd6, 3'd7, 8'h00, 2'd2, 3'd6, 4'd0, 2'd3, 3'd6},
    '{3'd7, 3'd7, 8'h00, 2'd0, 3'd0, 4'd0, 2'd0, 3'd0},
    '{3'd0, 3'd7, 8'h80, 2'd0, 3'd0, 4'd1, 2'd2, 3'd0},
    '{3'd0, 3'd7, 8'h00, 2'd0, 3'd0, 4'd2, 2'd0, 3'd0},
    '{3'd2, 3'd5, 8'h00, 2'd1, 3'd2, 4'd0, 2'd1, 3'd2}
  };

  logic clk, rst_n, start;
  logic [SWB-1:0] first, last, fail_sect;
  logic [NS-1:0]  prot;
  logic busy, done;
  logic [1:0] result;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;
  logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  flash_erase_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SECT_CNT(NS), .SECT_WOFS(TBL), .FLASH_BASE(BASE),
    .T_SU(2), .T_WP(2), .T_HD(1), .T_ACC(2), .TMO_CYC(TMO), .SETTLE_CYC(SETTLE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .first_i(first), .last_i(last),
    .protect_i(prot), .busy_o(busy), .done_o(done), .result_o(result),
    .fail_sect_o(fail_sect), .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o),
    .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n_o(fl_ce_n),
    .fl_we_n_o(fl_we_n), .fl_oe_n_o(fl_oe_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Flash model configuration, driven by the main process only
  logic [2:0] cfg_first, cfg_bad;
  logic [1:0] cfg_mode;
  int         cfg_polls;
  logic       m_clear;

  // Flash model state, written only by the model process
  int  m_wr, m_seq_err, m_rd, m_rd_err, m_ce_falls, m_poll_sect, cyc, last_we_cyc;
  logic prev_we, prev_oe, prev_ce;

  function automatic logic [AW-1:0] wbyte(input logic [WAW-1:0] w);
    return BASE + {w, 1'b0};
  endfunction

  function automatic logic [AW-1:0] sbase(input int s);
    return wbyte(TBL[s*WAW +: WAW]);
  endfunction

  always @(posedge clk) begin
    int k, s;
    logic [AW-1:0] ea;
    logic [7:0]    ed;
    cyc     <= cyc + 1;
    prev_we <= fl_we_n;
    prev_oe <= fl_oe_n;
    prev_ce <= fl_ce_n;
    if (m_clear) begin
      m_wr <= 0; m_seq_err <= 0; m_rd <= 0; m_rd_err <= 0; m_ce_falls <= 0;
      m_poll_sect <= -1;
    end else begin
      if (prev_ce && !fl_ce_n) m_ce_falls <= m_ce_falls + 1;
      if (!prev_we && fl_we_n) begin
        k = m_wr % 7;
        s = int'(cfg_first) + m_wr / 7;
        case (k)
          0, 3:    begin ea = wbyte(23'h555); ed = 8'hAA; end
          1, 4:    begin ea = wbyte(23'h2AA); ed = 8'h55; end
          2:       begin ea = wbyte(23'h555); ed = 8'h80; end
          5:       begin ea = sbase(s);       ed = 8'h30; end
          default: begin ea = wbyte(23'h555); ed = 8'hF0; end
        endcase
        if (fl_addr != ea || fl_dq_o != {8'h00, ed}) m_seq_err <= m_seq_err + 1;
        if (k == 5) begin m_poll_sect <= s; m_rd <= 0; end
        m_wr        <= m_wr + 1;
        last_we_cyc <= cyc;
      end
      if (!prev_oe && fl_oe_n) begin
        m_rd <= m_rd + 1;
        if (m_poll_sect < 0 || fl_addr != sbase(m_poll_sect)) m_rd_err <= m_rd_err + 1;
      end
    end
  end

  always_comb begin
    logic hit;
    hit = (m_poll_sect == int'(cfg_bad)) && (cfg_mode != 2'd0);
    if (hit && cfg_mode == 2'd2)   fl_dq_i = m_rd[0] ? 16'h0040 : 16'h0000;
    else if (m_rd < cfg_polls)     fl_dq_i = m_rd[0] ? 16'h0040 : 16'h0000;
    else if (hit)                  fl_dq_i = 16'h0020;
    else                           fl_dq_i = 16'hFFFF;
  end

  int n_chk, n_fail;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [2:0] f, input logic [2:0] l, input logic [7:0] m);
    @(negedge clk);
    first = f; last = l; prot = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got, output int gap);
    got = 1'b0;
    gap = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin
        got = 1'b1;
        gap = cyc - last_we_cyc;
        break;
      end
    end
  endtask

  task automatic setup_model(input logic [2:0] f, input logic [1:0] md,
                             input logic [2:0] b, input int p);
    @(negedge clk);
    cfg_first = f; cfg_mode = md; cfg_bad = b; cfg_polls = p; m_clear = 1'b1;
    @(negedge clk);
    m_clear = 1'b0;
  endtask

  bit timed_out;

  initial begin
    rst_n = 1'b0; start = 1'b0; first = '0; last = '0; prot = '0;
    cfg_first = '0; cfg_mode = '0; cfg_bad = '0; cfg_polls = 0; m_clear = 1'b1;
    cyc = 0; last_we_cyc = 0; prev_we = 1'b1; prev_oe = 1'b1; prev_ce = 1'b1;
    n_chk = 0; n_fail = 0; timed_out = 1'b0;
    fork
      begin : main
        bit got;
        int gap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        m_clear = 1'b0;
        // R9: reset state, bus idle
        check(!busy && !done, "R9 reset busy/done", {busy, done}, 0);
        check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R7 reset bus idle",
              {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);

        for (int v = 0; v < NV; v++) begin
          int nsec, expw;
          vec_t t;
          t = VECS[v];
          setup_model(t.first, t.mode, t.bad, int'(t.polls));
          pulse_start(t.first, t.last, t.mask);
          check(busy, "R9 busy after start", busy, 1);
          wait_done(got, gap);
          if (t.res == 2'd2)      nsec = 0;
          else if (t.mode == 2'd0) nsec = int'(t.last) - int'(t.first) + 1;
          else                    nsec = int'(t.bad) - int'(t.first) + 1;
          expw = nsec * 7;
          check(got, "R9 done pulse seen", got, 1);
          check(result == t.res, "R1/R4/R5 result code", result, t.res);
          check(m_wr == expw, "R2/R6/R8 write count", m_wr, expw);
          check(m_seq_err == 0, "R2/R3/R6 write sequence", m_seq_err, 0);
          check(m_rd_err == 0, "R4 poll address", m_rd_err, 0);
          if (t.res == 2'd2)
            check(m_ce_falls == 0, "R1 no bus cycle when protected", m_ce_falls, 0);
          if (t.res == 2'd1 || t.res == 2'd3)
            check(fail_sect == t.fsect, "R8 failing sector index", fail_sect, t.fsect);
          if (t.res == 2'd3)
            check(m_rd > 1, "R5 polled until timeout", m_rd, 2);
          if (t.res == 2'd0)
            check(gap >= int'(SETTLE), "R10 settle delay", gap, SETTLE);
          repeat (3) @(negedge clk);
        end

        // R11: first above last gives no bus cycles and result ok
        setup_model(3'd5, 2'd0, 3'd0, 0);
        pulse_start(3'd5, 3'd2, 8'h00);
        wait_done(got, gap);
        check(got && result == 2'd0, "R11 empty range result", result, 0);
        check(m_ce_falls == 0, "R11 empty range bus idle", m_ce_falls, 0);

        // R9: start while busy is ignored
        setup_model(3'd0, 2'd0, 3'd0, 2);
        pulse_start(3'd0, 3'd1, 8'h00);
        repeat (30) @(negedge clk);
        check(busy, "R9 busy mid run", busy, 1);
        pulse_start(3'd3, 3'd3, 8'h08);
        wait_done(got, gap);
        check(got && result == 2'd0, "R9 second start ignored result", result, 0);
        check(m_wr == 14, "R9 second start ignored writes", m_wr, 14);
        check(m_seq_err == 0, "R9 second start ignored sequence", m_seq_err, 0);
        @(negedge clk);
        check(!busy && !done, "R9 idle after done", {busy, done}, 0);
      end
      begin : wdog
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "R9 watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule